// File: doc/BRIEF.md
# Multiplexer Channel Address Latch Decoder

This block drives the switch selects of a sixteen-input analog front end built from two eight-way switch banks. The "high" bank serves channels 0-7 and the "low" bank serves channels 8-15. A channel number arrives on a 4-bit address bus. A pass-through control either lets that address through or freezes the last address that got through. In the block, this level-sensitive register is modelled as a clock-sampled enable.

The frozen address is decoded in one of two ways. The choice follows a mode input, which takes effect on the next clock and is never stored in the latch. In single-ended mode the four address bits name one switch out of sixteen. In paired (differential) mode the three low bits name a lane. The same lane then closes in both banks, but only if the top address bit is 1. A top bit of 0 leaves every switch open.

The selects, the per-bank enables and a settling-busy flag all come from registers. The busy flag covers the analog settling time after an address or mode change, counted in clock cycles.

Top module: `chan_sel_decoder`

## Requirements
- R1: While reset is asserted, every select, both bank enables and busy are 0. The stored address resets to 0, so after reset with pass-through low the selects show high-bank lane 0.
- R2: With `pass_i` = 1, the selects reflect `addr_i` one clock edge after it is sampled.
- R3: With `pass_i` = 0, changes on `addr_i` have no effect. The stored address is the one sampled at the last edge where `pass_i` was 1.
- R4: In single-ended mode (`diff_i` = 0), an address 0-7 drives exactly `hi_sel_o[addr[2:0]]`, and `lo_sel_o` is all 0.
- R5: In single-ended mode, an address 8-15 drives exactly `lo_sel_o[addr[2:0]]`, and `hi_sel_o` is all 0.
- R6: In differential mode (`diff_i` = 1) with address bit 3 = 1, both `hi_sel_o[addr[2:0]]` and `lo_sel_o[addr[2:0]]` are 1 and no other select is.
- R7: In differential mode with address bit 3 = 0, every select is 0.
- R8: The mode is not latched. A change of `diff_i` re-decodes the stored address at the next edge, even while `pass_i` = 0.
- R9: `hi_en_o` and `lo_en_o` are 1 exactly when at least one select of their bank is 1.
- R10: At most one select per bank is 1 in any cycle.
- R11: A change of the stored address raises `busy_o` for ADDR_SETTLE_CYC cycles, starting with the edge that applies the change.
- R12: A change of `diff_i` alone raises `busy_o` for MODE_SETTLE_CYC cycles. A simultaneous address and mode change lasts only the longer of the two intervals.
- R13: When changes overlap, `busy_o` stays high until the latest-ending interval still pending has run out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Channel address |
| pass_i | input | 1 | 1: address passes through; 0: address frozen |
| diff_i | input | 1 | 0: single-ended decode; 1: paired decode |
| hi_sel_o | output | 2**(ADDR_W-1) | One-hot selects of the high bank |
| lo_sel_o | output | 2**(ADDR_W-1) | One-hot selects of the low bank |
| hi_en_o | output | 1 | High bank has a closed switch |
| lo_en_o | output | 1 | Low bank has a closed switch |
| busy_o | output | 1 | Analog path still settling |

## Verification
The decoder is driven through a full sweep of all sixteen addresses in each mode. In single-ended mode this separates the bank choice made by bit 3. In paired mode it separates the lane pair from the all-open case. Address traffic with pass-through low, including a change in the same cycle pass-through drops, shows whether the latch freezes the right value. Mode toggles with the latch frozen show whether the mode is applied live.

Changes are also applied one at a time, together, and overlapping in both orders. The busy length then tells apart the address interval, the mode interval, the longer of the two when they coincide, and the longest one still pending.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_PAIR   = 1'b1
    } chsel_mode_e;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/chsel_addr_hold.sv
module chsel_addr_hold #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pass_en,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_nxt,
    output logic              addr_moved
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pass_en) begin
            st_d.addr = addr_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_nxt   = st_d.addr;
    assign addr_moved = (st_d.addr != st_q.addr);

endmodule

// File: rtl/chsel_route.sv
module chsel_route
    import chsel_pkg::*;
#(
    parameter  int ADDR_W = 4,
    localparam int BANK_N = 1 << (ADDR_W - 1)
) (
    input  logic [ADDR_W-1:0] addr,
    input  chsel_mode_e       mode,
    output logic [BANK_N-1:0] hi_sel,
    output logic [BANK_N-1:0] lo_sel
);

    localparam int LANE_W = ADDR_W - 1;

    logic              upper;
    logic [LANE_W-1:0] lane;

    assign upper = addr[ADDR_W-1];
    assign lane  = addr[LANE_W-1:0];

    // Each lane closes in the low bank whenever the upper bit is set; in the
    // high bank it closes for a low address (single) or alongside its partner (pair).
    generate
        for (genvar i = 0; i < BANK_N; i++) begin : g_lane
            logic hit;
            assign hit       = (lane == LANE_W'(i));
            assign hi_sel[i] = hit & ((mode == MODE_PAIR) ? upper : ~upper);
            assign lo_sel[i] = hit & upper;
        end
    endgenerate

endmodule

// File: rtl/chsel_settle.sv
module chsel_settle
    import chsel_pkg::*;
#(
    parameter  int unsigned ADDR_CYC = 300,
    parameter  int unsigned MODE_CYC = 200,
    localparam int unsigned LONG_CYC = umax(ADDR_CYC, MODE_CYC),
    localparam int unsigned CNT_W    = $clog2(LONG_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic addr_moved,
    input  logic mode_moved,
    output logic busy
);

    typedef struct packed {
        logic [CNT_W-1:0] left;
    } settle_st_t;

    settle_st_t st_d, st_q;

    logic [CNT_W-1:0] carry_left;
    logic [CNT_W-1:0] need_addr;
    logic [CNT_W-1:0] need_mode;
    logic [CNT_W-1:0] need;

    always_comb begin
        carry_left = (st_q.left == '0) ? '0 : st_q.left - 1'b1;
        need_addr  = addr_moved ? CNT_W'(ADDR_CYC) : '0;
        need_mode  = mode_moved ? CNT_W'(MODE_CYC) : '0;
        need       = (need_addr > need_mode) ? need_addr : need_mode;
        st_d       = st_q;
        st_d.left  = (need > carry_left) ? need : carry_left;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.left != '0);

endmodule

// File: rtl/chan_sel_decoder.sv
module chan_sel_decoder
    import chsel_pkg::*;
#(
    parameter  int          ADDR_W          = 4,
    parameter  int unsigned ADDR_SETTLE_CYC = 300,
    parameter  int unsigned MODE_SETTLE_CYC = 200,
    localparam int          BANK_N          = 1 << (ADDR_W - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              pass_i,
    input  logic              diff_i,
    output logic [BANK_N-1:0] hi_sel_o,
    output logic [BANK_N-1:0] lo_sel_o,
    output logic              hi_en_o,
    output logic              lo_en_o,
    output logic              busy_o
);

    typedef struct packed {
        logic [BANK_N-1:0] hi;
        logic [BANK_N-1:0] lo;
        logic              hi_en;
        logic              lo_en;
        logic              mode;
    } out_st_t;

    out_st_t st_d, st_q;

    logic [ADDR_W-1:0] addr_nxt;
    logic              addr_moved;
    logic              mode_moved;
    chsel_mode_e       mode_now;
    logic [BANK_N-1:0] route_hi;
    logic [BANK_N-1:0] route_lo;

    chsel_addr_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .pass_en    (pass_i),
        .addr_in    (addr_i),
        .addr_nxt   (addr_nxt),
        .addr_moved (addr_moved)
    );

    assign mode_now = diff_i ? MODE_PAIR : MODE_SINGLE;

    chsel_route #(.ADDR_W(ADDR_W)) u_route (
        .addr   (addr_nxt),
        .mode   (mode_now),
        .hi_sel (route_hi),
        .lo_sel (route_lo)
    );

    always_comb begin
        st_d       = st_q;
        st_d.hi    = route_hi;
        st_d.lo    = route_lo;
        st_d.hi_en = |route_hi;
        st_d.lo_en = |route_lo;
        st_d.mode  = diff_i;
    end

    assign mode_moved = (st_d.mode != st_q.mode);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    chsel_settle #(
        .ADDR_CYC (ADDR_SETTLE_CYC),
        .MODE_CYC (MODE_SETTLE_CYC)
    ) u_settle (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_moved (addr_moved),
        .mode_moved (mode_moved),
        .busy       (busy_o)
    );

    assign hi_sel_o = st_q.hi;
    assign lo_sel_o = st_q.lo;
    assign hi_en_o  = st_q.hi_en;
    assign lo_en_o  = st_q.lo_en;

endmodule

// File: rtl/chsel_checker.sv
module chsel_checker #(
    parameter int BANK_N = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pass_i,
    input logic              diff_i,
    input logic [BANK_N-1:0] hi_sel_o,
    input logic [BANK_N-1:0] lo_sel_o,
    input logic              hi_en_o,
    input logic              lo_en_o,
    input logic              busy_o
);

    logic [1:0] age_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    // R10: never two closed switches in one bank
    p_bank_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hi_sel_o) && $onehot0(lo_sel_o));

    // R9: bank enables agree with the bank selects
    p_bank_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_en_o == (hi_sel_o != '0)) && (lo_en_o == (lo_sel_o != '0)));

    // R4 / R5: single-ended decode closes exactly one switch overall
    p_single_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0) && !$past(diff_i) |-> $countones({hi_sel_o, lo_sel_o}) == 1);

    // R6: paired decode closes matching lanes in both banks
    p_pair_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0) && $past(diff_i) |-> hi_sel_o == lo_sel_o);

    // R3: frozen latch with steady mode keeps the selects unchanged
    p_frozen_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) && !$past(pass_i) && ($past(diff_i) == $past(diff_i, 2))
        |-> $stable(hi_sel_o) && $stable(lo_sel_o));

    // R12: a mode change reports settling
    p_mode_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) && ($past(diff_i) != $past(diff_i, 2)) |-> busy_o);

endmodule

bind chan_sel_decoder chsel_checker #(.BANK_N(BANK_N)) u_chsel_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pass_i   (pass_i),
    .diff_i   (diff_i),
    .hi_sel_o (hi_sel_o),
    .lo_sel_o (lo_sel_o),
    .hi_en_o  (hi_en_o),
    .lo_en_o  (lo_en_o),
    .busy_o   (busy_o)
);

// File: tb/tb_chan_sel_decoder.sv
module tb_chan_sel_decoder;

    localparam int AW = 4;
    localparam int BN = 8;
    localparam int AC = 12;
    localparam int MC = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          pass = 1'b0;
    logic          diff = 1'b0;
    logic [BN-1:0] hi_sel, lo_sel;
    logic          hi_en, lo_en, busy;

    always #10 clk = ~clk;

    chan_sel_decoder #(
        .ADDR_W          (AW),
        .ADDR_SETTLE_CYC (AC),
        .MODE_SETTLE_CYC (MC)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (addr),
        .pass_i   (pass),
        .diff_i   (diff),
        .hi_sel_o (hi_sel),
        .lo_sel_o (lo_sel),
        .hi_en_o  (hi_en),
        .lo_en_o  (lo_en),
        .busy_o   (busy)
    );

    typedef struct {
        logic [BN-1:0] hi;
        logic [BN-1:0] lo;
        logic          busy;
        string         tag;
    } exp_t;

    exp_t expq[$];
    int   n_chk  = 0;
    int   n_fail = 0;

    logic [AW-1:0] m_held = '0;
    logic          m_diff = 1'b0;
    int            m_rem  = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus and queue what must appear after the next edge
    task automatic step(input logic [AW-1:0] a, input logic p, input logic d, input string tag);
        exp_t          e;
        logic [AW-1:0] nh;
        int            need;
        @(negedge clk);
        addr = a;
        pass = p;
        diff = d;
        nh   = p ? a : m_held;
        need = 0;
        if (nh != m_held) need = AC;
        if (d != m_diff && MC > need) need = MC;
        m_rem  = (m_rem > 0) ? m_rem - 1 : 0;
        if (need > m_rem) m_rem = need;
        m_held = nh;
        m_diff = d;
        e.hi = '0;
        e.lo = '0;
        if (!d) begin
            if (nh[AW-1]) e.lo[nh[AW-2:0]] = 1'b1;
            else          e.hi[nh[AW-2:0]] = 1'b1;
        end else if (nh[AW-1]) begin
            e.hi[nh[AW-2:0]] = 1'b1;
            e.lo[nh[AW-2:0]] = 1'b1;
        end
        e.busy = (m_rem != 0);
        e.tag  = tag;
        expq.push_back(e);
    endtask

    // monitor: compare after each rising edge, away from both edges
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (expq.size() > 0) begin
                exp_t e;
                e = expq.pop_front();
                check(hi_sel == e.hi, e.tag, "hi_sel", 32'(hi_sel), 32'(e.hi));
                check(lo_sel == e.lo, e.tag, "lo_sel", 32'(lo_sel), 32'(e.lo));
                check(busy == e.busy, e.tag, "busy", 32'(busy), 32'(e.busy));
                check(hi_en == (e.hi != '0) && lo_en == (e.lo != '0), "R9", "enables",
                      32'({hi_en, lo_en}), 32'({e.hi != '0, e.lo != '0}));
                check($countones(hi_sel) <= 1 && $countones(lo_sel) <= 1, "R10", "one per bank",
                      32'({hi_sel, lo_sel}), 32'({e.hi, e.lo}));
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(hi_sel == '0 && lo_sel == '0, "R1", "selects in reset",
              32'({hi_sel, lo_sel}), 32'h0);
        check(!hi_en && !lo_en && !busy, "R1", "enables/busy in reset",
              32'({hi_en, lo_en, busy}), 32'h0);
        rst_n = 1'b1;

        // R1 / R3: frozen latch still holds the reset address 0
        step(4'd9, 1'b0, 1'b0, "R1");
        for (int i = 0; i < 3; i++) step(4'(i * 5 + 3), 1'b0, 1'b0, "R3");

        // R2 / R4 / R5 / R11: single-ended sweep with pass-through
        for (int a = 0; a < 16; a++) step(4'(a), 1'b1, 1'b0, (a < 8) ? "R4" : "R5");
        step(4'd15, 1'b1, 1'b0, "R2");
        for (int i = 0; i < 14; i++) step(4'd15, 1'b0, 1'b0, "R11");

        // R3: freeze in the same cycle the address moves
        step(4'd5, 1'b1, 1'b0, "R2");
        step(4'd6, 1'b0, 1'b0, "R3");
        for (int i = 0; i < 6; i++) step(4'(i + 9), 1'b0, 1'b0, "R3");
        for (int i = 0; i < 10; i++) step(4'd0, 1'b0, 1'b0, "R11");

        // R8 / R12: live mode change while frozen (held 5 -> all open in pair mode)
        step(4'd12, 1'b0, 1'b1, "R8");
        for (int i = 0; i < 9; i++) step(4'd12, 1'b0, 1'b1, "R12");

        // R6 / R7: paired sweep
        for (int a = 0; a < 16; a++) step(4'(a), 1'b1, 1'b1, a[3] ? "R6" : "R7");
        for (int i = 0; i < 14; i++) step(4'd15, 1'b1, 1'b1, "R11");

        // R12: address and mode together last only the longer interval
        step(4'd2, 1'b1, 1'b0, "R12");
        for (int i = 0; i < 14; i++) step(4'd2, 1'b1, 1'b0, "R12");

        // R13: mode change, then an address change three cycles later
        step(4'd2, 1'b1, 1'b1, "R13");
        for (int i = 0; i < 3; i++) step(4'd2, 1'b1, 1'b1, "R13");
        step(4'd10, 1'b1, 1'b1, "R13");
        for (int i = 0; i < 14; i++) step(4'd10, 1'b1, 1'b1, "R13");

        // R13: address change, then a shorter mode change two cycles later
        step(4'd3, 1'b1, 1'b1, "R13");
        for (int i = 0; i < 2; i++) step(4'd3, 1'b0, 1'b1, "R13");
        step(4'd3, 1'b0, 1'b0, "R13");
        for (int i = 0; i < 14; i++) step(4'd7, 1'b0, 1'b0, "R13");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule